// File: doc/BRIEF.md
# Stereo Audio Serial Port (Slave, Four Formats)

This block is the digital serial edge of a stereo converter. An external master supplies the bit clock and the frame clock. The block samples both clocks with its own faster system clock. It shifts out a 20-bit two's-complement transmit word for each channel, MSB first, and it collects the incoming serial bits into a left and a right receive word. Both words are issued together with a one-cycle valid strobe once a whole frame has been captured.

A 2-bit format input selects one of four framings. In three of them the left channel is sent while the frame clock is high and the transmit word is MSB-justified. Their receive side differs: it is 16-bit right-aligned, 20-bit right-aligned, or 20-bit MSB-justified. The fourth format is I2S in both directions: the left channel is sent while the frame clock is low, and the MSB follows the frame edge by one bit clock. The format is meant to be static while the block runs, and a change of format is followed by a reset. Serial data changes on falling bit-clock edges and is captured on rising edges. Each bit-clock phase must last at least four system clocks.

Top module: `stereo_serial_port`

## Requirements
- R1: In reset and afterwards, `ser_out`, `rx_valid`, `rx_left` and `rx_right` are 0. `ser_out` stays 0 until the first left half that begins with an observed frame-clock transition.
- R2: The left half is frame clock high in formats 0, 1 and 2, and frame clock low in format 3 (I2S). A new half begins at the first bit-clock edge on which the sampled frame clock differs from its previous sample.
- R3: Transmit in formats 0, 1 and 2 places the MSB on the falling edge where the frame clock toggles. Bit 19-j is driven on the j-th falling edge after that one. All bits after the LSB are 0, and if the half is shorter than 20 bits the LSBs are dropped.
- R4: Transmit in format 3 drives 0 on the toggling falling edge and the MSB one falling edge later. Bits past the LSB are 0. At 16 bit clocks per half only the top 15 bits are sent.
- R5: Both transmit words are captured together when the left half begins. A change of `tx_right` during the left half does not alter the right half of that frame.
- R6: Receive format 0 keeps the last 16 bits before the frame-clock toggle and reports them as {bits, 4'b0000}. Earlier bits are ignored.
- R7: Receive format 1 keeps the last 20 bits before the frame-clock toggle. Earlier bits are ignored.
- R8: Receive format 2 takes the first 20 rising edges of a half, starting at the edge after the toggle, as bits 19 down to 0. Later bits are ignored. LSBs that a short half never reaches read 0.
- R9: Receive format 3 skips the first rising edge of a half and takes the next 20 as bits 19 down to 0. LSBs that a short half never reaches read 0.
- R10: `rx_valid` pulses for one system clock at the start of a left half that follows a complete left half and a complete right half. Each of those two halves must have been opened by a frame-clock toggle. `rx_left` and `rx_right` change only with that pulse.
- R11: `ser_out` changes only on the third system clock edge after a falling bit-clock edge reaches the pin, and it is never later than that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversampling the serial clocks |
| rst | input | 1 | Synchronous active-high reset |
| fmt | input | 2 | Format select 0..3 (static during operation) |
| bit_clk | input | 1 | External bit clock |
| frame_clk | input | 1 | External frame (left/right) clock |
| ser_in | input | 1 | Serial receive data |
| ser_out | output | 1 | Serial transmit data, registered |
| tx_left | input | 20 | Left transmit word, two's complement |
| tx_right | input | 20 | Right transmit word, two's complement |
| rx_left | output | 20 | Last complete left receive word |
| rx_right | output | 20 | Last complete right receive word |
| rx_valid | output | 1 | One-cycle strobe for a new receive pair |

## Verification
A bit-clock edge is seen by the logic two system clocks after it reaches the pin, so `ser_out` moves on the third system clock edge. The bench reads it four system clocks after each falling edge, which is still four clocks before the next rising edge. `rx_valid` is due three system clocks after the first rising edge of the next left half. The bench counts strobes around that bit and compares them only after the full bit period has elapsed. No check is placed in a cycle where a result is still in flight.

// File: rtl/sport_pkg.sv
package sport_pkg;
  typedef enum logic [1:0] {
    FMT_L16 = 2'd0,
    FMT_L20 = 2'd1,
    FMT_MSB = 2'd2,
    FMT_I2S = 2'd3
  } fmt_e;

  // true when the sampled frame clock level denotes the left half
  function automatic logic left_half(input logic [1:0] fmt, input logic lr);
    return (fmt == FMT_I2S) ? ~lr : lr;
  endfunction

  // receive word is aligned to the end of the half
  function automatic logic tail_aligned(input logic [1:0] fmt);
    return (fmt == FMT_L16) || (fmt == FMT_L20);
  endfunction
endpackage

// File: rtl/sport_sync.sv
module sport_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bclk,
  input  logic lrclk,
  input  logic sdin,
  output logic rise,
  output logic fall,
  output logic lr_s,
  output logic sd_s
);
  logic [STAGES:0]   b_pipe;
  logic [STAGES-1:0] l_pipe;
  logic [STAGES-1:0] d_pipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      b_pipe <= '0;
      l_pipe <= '0;
      d_pipe <= '0;
    end else begin
      b_pipe <= {b_pipe[STAGES-1:0], bclk};
      l_pipe <= {l_pipe[STAGES-2:0], lrclk};
      d_pipe <= {d_pipe[STAGES-2:0], sdin};
    end
  end

  assign rise = b_pipe[STAGES-1] & ~b_pipe[STAGES];
  assign fall = ~b_pipe[STAGES-1] & b_pipe[STAGES];
  assign lr_s = l_pipe[STAGES-1];
  assign sd_s = d_pipe[STAGES-1];
endmodule

// File: rtl/sport_tx.sv
module sport_tx import sport_pkg::*; #(
  parameter int W  = 20,
  parameter int CW = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         fall,
  input  logic         lr_s,
  input  logic [1:0]   fmt,
  input  logic [W-1:0] word_l,
  input  logic [W-1:0] word_r,
  output logic         sd
);
  localparam int IW = $clog2(W);
  localparam logic [CW-1:0] CMAX = '1;

  logic          primed, live, lr_prev;
  logic [CW-1:0] cnt, cnt_nxt, pos;
  logic [W-1:0]  hold_l, hold_r, word;
  logic          start, left_now, bit_on;
  logic [IW-1:0] idx;

  always_comb begin
    left_now = left_half(fmt, lr_s);
    start    = primed && (lr_s != lr_prev);
    cnt_nxt  = start ? '0 : ((cnt == CMAX) ? cnt : cnt + 1'b1);
    if (start && left_now) word = word_l;
    else if (left_now)     word = hold_l;
    else                   word = hold_r;
    if (fmt == FMT_I2S) begin
      bit_on = (cnt_nxt != '0) && (cnt_nxt <= CW'(W));
      pos    = cnt_nxt - 1'b1;
    end else begin
      bit_on = cnt_nxt < CW'(W);
      pos    = cnt_nxt;
    end
    idx = IW'(W - 1) - IW'(pos);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      primed  <= 1'b0;
      live    <= 1'b0;
      lr_prev <= 1'b0;
      cnt     <= '0;
      hold_l  <= '0;
      hold_r  <= '0;
      sd      <= 1'b0;
    end else if (fall) begin
      primed  <= 1'b1;
      lr_prev <= lr_s;
      cnt     <= cnt_nxt;
      if (start && left_now) begin
        live   <= 1'b1;
        hold_l <= word_l;
        hold_r <= word_r;
      end
      sd <= (live || (start && left_now)) && bit_on && word[idx];
    end
  end

  // R11: the serial output moves only one cycle after a detected falling edge
  assert_out_moves_on_fall_R11: assert property (@(posedge clk) disable iff (rst)
    !$past(fall) |-> $stable(sd));
endmodule

// File: rtl/sport_rx.sv
module sport_rx import sport_pkg::*; #(
  parameter int W  = 20,
  parameter int SW = 16,
  parameter int CW = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rise,
  input  logic         lr_s,
  input  logic         sd_s,
  input  logic [1:0]   fmt,
  output logic [W-1:0] rx_left,
  output logic [W-1:0] rx_right,
  output logic         rx_valid
);
  localparam int IW  = $clog2(W);
  localparam int PAD = W - SW;
  localparam logic [CW-1:0] CMAX = '1;

  logic          primed, clean, have_l, lr_prev;
  logic [CW-1:0] cnt, cnt_nxt, pos;
  logic [W-1:0]  acc, acc_nxt, part_l, done_word;
  logic          start, prev_left, bit_on;
  logic [IW-1:0] idx;

  always_comb begin
    start     = primed && (lr_s != lr_prev);
    prev_left = left_half(fmt, lr_prev);
    cnt_nxt   = start ? '0 : ((cnt == CMAX) ? cnt : cnt + 1'b1);
    done_word = (fmt == FMT_L16) ? {acc[SW-1:0], {PAD{1'b0}}} : acc;
    if (fmt == FMT_I2S) begin
      bit_on = (cnt_nxt != '0) && (cnt_nxt <= CW'(W));
      pos    = cnt_nxt - 1'b1;
    end else begin
      bit_on = cnt_nxt < CW'(W);
      pos    = cnt_nxt;
    end
    idx     = IW'(W - 1) - IW'(pos);
    acc_nxt = start ? '0 : acc;
    if (tail_aligned(fmt)) acc_nxt = {acc_nxt[W-2:0], sd_s};
    else if (bit_on)       acc_nxt[idx] = sd_s;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      primed   <= 1'b0;
      clean    <= 1'b0;
      have_l   <= 1'b0;
      lr_prev  <= 1'b0;
      cnt      <= '0;
      acc      <= '0;
      part_l   <= '0;
      rx_left  <= '0;
      rx_right <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (rise) begin
        primed  <= 1'b1;
        lr_prev <= lr_s;
        cnt     <= cnt_nxt;
        acc     <= acc_nxt;
        if (start) begin
          clean <= 1'b1;
          if (clean) begin
            if (prev_left) begin
              part_l <= done_word;
              have_l <= 1'b1;
            end else if (have_l) begin
              rx_left  <= part_l;
              rx_right <= done_word;
              rx_valid <= 1'b1;
              have_l   <= 1'b0;
            end
          end
        end
      end
    end
  end

  // R10: strobe lasts one cycle
  assert_valid_single_R10: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);
  // R10: receive words change only together with the strobe
  assert_words_held_R10: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |-> ($stable(rx_left) && $stable(rx_right)));
  // R10: a strobe always follows a detected rising bit-clock edge
  assert_valid_after_rise_R10: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> $past(rise));
endmodule

// File: rtl/stereo_serial_port.sv
module stereo_serial_port #(
  parameter int WORD_W      = 20,
  parameter int SHORT_W     = 16,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        fmt,
  input  logic              bit_clk,
  input  logic              frame_clk,
  input  logic              ser_in,
  output logic              ser_out,
  input  logic [WORD_W-1:0] tx_left,
  input  logic [WORD_W-1:0] tx_right,
  output logic [WORD_W-1:0] rx_left,
  output logic [WORD_W-1:0] rx_right,
  output logic              rx_valid
);
  logic bclk_rise, bclk_fall, lr_s, sd_s;

  sport_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .bclk(bit_clk), .lrclk(frame_clk), .sdin(ser_in),
    .rise(bclk_rise), .fall(bclk_fall), .lr_s(lr_s), .sd_s(sd_s)
  );

  sport_tx #(.W(WORD_W), .CW(CNT_W)) u_tx (
    .clk(clk), .rst(rst), .fall(bclk_fall), .lr_s(lr_s), .fmt(fmt),
    .word_l(tx_left), .word_r(tx_right), .sd(ser_out)
  );

  sport_rx #(.W(WORD_W), .SW(SHORT_W), .CW(CNT_W)) u_rx (
    .clk(clk), .rst(rst), .rise(bclk_rise), .lr_s(lr_s), .sd_s(sd_s), .fmt(fmt),
    .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid)
  );
endmodule

// File: tb/stereo_serial_port_bench.sv
module stereo_serial_port_bench;
  localparam int W = 20;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst = 1'b1;
  logic [1:0]   fmt = 2'd0;
  logic         bclk = 1'b1, lrclk = 1'b0, sdin = 1'b0;
  logic [W-1:0] tx_l = '0, tx_r = '0;
  logic         sdout, rx_v;
  logic [W-1:0] rx_l, rx_r;

  int checks = 0, errors = 0, vcount = 0;
  logic [W-1:0] cap_l = '0, cap_r = '0;
  bit done = 1'b0;

  stereo_serial_port u_stereo_serial_port (
    .clk(clk), .rst(rst), .fmt(fmt), .bit_clk(bclk), .frame_clk(lrclk),
    .ser_in(sdin), .ser_out(sdout), .tx_left(tx_l), .tx_right(tx_r),
    .rx_left(rx_l), .rx_right(rx_r), .rx_valid(rx_v)
  );

  always @(posedge clk) if (rx_v) begin
    vcount++;
    cap_l = rx_l;
    cap_r = rx_r;
  end

  // fields: mode, bits per half, tx left, tx right, rx left, rx right
  localparam logic [89:0] VEC [9] = '{
    {2'd0, 8'd32, 20'hABCDE, 20'h12345, 20'h0BEEF, 20'h08001},
    {2'd0, 8'd16, 20'h80001, 20'h7FFFE, 20'h0C3A5, 20'h05A5A},
    {2'd1, 8'd32, 20'h5A5A5, 20'hF0F0F, 20'h81234, 20'h7EDCB},
    {2'd1, 8'd20, 20'h00001, 20'hFFFFF, 20'h96969, 20'h00F00},
    {2'd2, 8'd32, 20'h3C3C3, 20'hC0FFE, 20'hA5A5A, 20'h13579},
    {2'd2, 8'd24, 20'h24680, 20'h9BDF1, 20'h00001, 20'h80000},
    {2'd3, 8'd32, 20'h6B6B6, 20'h19E37, 20'h2468A, 20'hFEDCB},
    {2'd3, 8'd16, 20'hD00D5, 20'h1CAFE, 20'hBCDEF, 20'h7654F},
    {2'd3, 8'd20, 20'h0F0F0, 20'hE1E1E, 20'h55555, 20'hAAAAA}
  };

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // expected parallel receive word
  function automatic logic [W-1:0] exp_rx(input int m, input int half, input logic [W-1:0] w);
    int n;
    if (m == 0) return {w[15:0], 4'h0};
    if (m == 1) return w;
    n = (m == 2) ? half : half - 1;
    if (n > W) n = W;
    return w & ~((20'h1 << (W - n)) - 20'h1);
  endfunction

  // serial bit driven at position k of a half (1 where the bit is a don't care)
  function automatic logic rx_bit(input int m, input int half, input logic [W-1:0] w, input int k);
    int e;
    e = half - 1 - k;
    case (m)
      0: return (e < 16) ? w[e] : 1'b1;
      1: return (e < W) ? w[e] : 1'b1;
      2: return (k < W) ? w[W-1-k] : 1'b1;
      default: return (k >= 1 && k <= W) ? w[W-k] : 1'b1;
    endcase
  endfunction

  // expected transmit bit at position k of a half
  function automatic logic tx_bit(input int m, input logic [W-1:0] w, input int k);
    int j;
    j = (m == 3) ? k - 1 : k;
    return (j >= 0 && j < W) ? w[W-1-j] : 1'b0;
  endfunction

  task automatic do_bit(input logic lvl, input logic d, output logic txb);
    @(negedge clk);
    bclk = 1'b0; lrclk = lvl; sdin = d;
    repeat (4) @(negedge clk);
    txb = sdout;
    repeat (4) @(negedge clk);
    bclk = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  initial begin : main
    logic b;
    for (int v = 0; v < 9; v++) begin
      logic [89:0] e;
      int m, half, mism, vb;
      logic lvl_l, lvl;
      logic [W-1:0] txl, txr, rxl, rxr, wexp, rxw;
      string ttag, rtag;
      e = VEC[v];
      m = int'(e[89:88]); half = int'(e[87:80]);
      txl = e[79:60]; txr = e[59:40]; rxl = e[39:20]; rxr = e[19:0];
      lvl_l = (m == 3) ? 1'b0 : 1'b1;
      ttag = (m == 3) ? "R2,R4 tx" : "R2,R3 tx";
      rtag = (m == 0) ? "R6,R10 rx" : (m == 1) ? "R7,R10 rx" : (m == 2) ? "R8,R10 rx" : "R9,R10 rx";
      fmt = m[1:0]; tx_l = txl; tx_r = txr;
      rst = 1'b1; bclk = 1'b1; lrclk = ~lvl_l; sdin = 1'b0;
      repeat (5) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check(sdout == 1'b0 && rx_v == 1'b0 && rx_l == '0 && rx_r == '0,
            "R1 reset state", rx_l | rx_r | {18'b0, sdout, rx_v}, '0);
      // right half before any clean left start: output must stay low
      mism = 0;
      for (int k = 0; k < half; k++) begin
        do_bit(~lvl_l, 1'b1, b);
        if (b !== 1'b0) mism++;
      end
      check(mism == 0, "R1 quiet before first left half", W'(mism), '0);
      for (int f = 0; f < 2; f++) begin
        for (int s = 0; s < 2; s++) begin
          lvl  = s ? ~lvl_l : lvl_l;
          wexp = s ? txr : txl;
          rxw  = s ? rxr : rxl;
          mism = 0;
          for (int k = 0; k < half; k++) begin
            vb = vcount;
            do_bit(lvl, rx_bit(m, half, rxw, k), b);
            if (b !== tx_bit(m, wexp, k)) mism++;
            if (s == 0 && k == 0) begin
              if (f == 0) begin
                check(vcount == vb, "R10 no strobe before a full pair", W'(vcount - vb), '0);
              end else begin
                check(vcount == vb + 1, "R10 strobe count", W'(vcount - vb), 20'd1);
                check(cap_l == exp_rx(m, half, rxl), {rtag, " left"}, cap_l, exp_rx(m, half, rxl));
                check(cap_r == exp_rx(m, half, rxr), {rtag, " right"}, cap_r, exp_rx(m, half, rxr));
              end
            end
            // R5: change the right word after the left half has started
            if (f == 1 && s == 0 && k == 2) tx_r = ~txr;
          end
          if (f == 1 && s == 1)
            check(mism == 0, {ttag, " R5 right word held from left start, R11"}, W'(mism), '0);
          else
            check(mism == 0, {ttag, " R11 bit mismatches"}, W'(mism), '0);
        end
      end
      tx_r = txr;
      vb = vcount;
      do_bit(lvl_l, 1'b1, b);
      check(vcount == vb + 1, "R10 final strobe", W'(vcount - vb), 20'd1);
      check(cap_l == exp_rx(m, half, rxl) && cap_r == exp_rx(m, half, rxr),
            {rtag, " final pair"}, cap_l ^ cap_r, exp_rx(m, half, rxl) ^ exp_rx(m, half, rxr));
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule